// File: doc/BRIEF.md
# System Clock Mode Controller

This block decides which of three oscillators clocks the CPU and which oscillators run. The three sources are an internal ring oscillator, a high-speed main oscillator and a low-speed subsystem oscillator. Software writes a four-bit control word. The controller compares that word with the control word of its current clock status and moves to a new status only when the graph allows that one step. A rejected write leaves everything as it was and raises a one-cycle error pulse.

The block also runs the low-power modes. HALT freezes the CPU clock and STOP shuts the oscillators down. An interrupt brings the CPU back to the status it left. A stabilization counter guards every start of the main oscillator. A strap input selects whether software may stop the ring oscillator. When that option is set, the watchdog clock is gated off in both low-power modes.

The glitch-free clock multiplexer and the oscillators are outside the block. They are driven by its select and enable outputs.

Top module: `clkmode_ctrl`

Control word bits: bit 0 stops the main oscillator, bit 1 stops the ring oscillator, bit 2 selects the main clock, and bit 3 selects the subsystem clock. Each clock status has one fixed control word:

| Status | Control word |
|---|---|
| Ring only | 0001 |
| Ring with main running | 0000 |
| Main | 0100 |
| Main only | 0110 |
| Subsystem | 1100 |

The `cpu_src` encoding is 0 for ring, 1 for main and 2 for subsystem.

## Requirements
- R1: After reset the CPU runs from the ring oscillator (cpu_src=0) with the main oscillator stopped. Ring and watchdog clocks are on, the CPU clock is enabled, and mcs, stab_done and wr_err are all 0.
- R2: In the ring-only status, writing 0000 starts the main oscillator while cpu_src stays 0.
- R3: In the ring-with-main status, writing 0001 stops the main oscillator, but only while mcs reads 0. Otherwise the write is rejected.
- R4: In the ring-with-main status, writing 0100 moves the CPU to the main clock (cpu_src=1), but only while stab_done is 1.
- R5: stab_done rises exactly stab_count cycles after main_osc_en rises. The counter reloads whenever the main oscillator is off, which includes reset and STOP.
- R6: In the main status, writing 0110 stops the ring oscillator. This is accepted only when mcs is 1 and ring_sw_stop_opt is 1.
- R7: Writing 1100 from the main status selects the subsystem clock (cpu_src=2), and writing 0100 there returns to the main status. Any other write from the subsystem status is rejected, and so is any write reaching the subsystem status from a status other than main.
- R8: A rejected write leaves all outputs unchanged and pulses wr_err for one cycle. A write equal to the current control word is accepted with no effect. A write that changes more than one bit is rejected.
- R9: mcs goes to 1 one cycle after the CPU switches onto the main clock, and goes to 0 one cycle after it leaves.
- R10: halt_req drops cpu_clk_en and keeps the oscillators as they are. irq resumes the same status.
- R11: stop_req stops the main oscillator and, when the option is set, the ring oscillator, while the subsystem oscillator keeps running. After irq, cpu_clk_en stays 0 until stab_done if the CPU source is main.
- R12: With ring_sw_stop_opt=1, wdt_clk_en is 0 in HALT and STOP. With the option at 0, the ring oscillator and the watchdog clock stay on in every mode.
- R13: A write made during HALT or STOP is rejected with wr_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Combined active-low reset of all reset sources, asynchronous |
| ring_sw_stop_opt | input | 1 | Strap: software may stop the ring oscillator |
| wr_en | input | 1 | Control word write strobe |
| wr_ctrl | input | 4 | Control word written |
| halt_req | input | 1 | Enter HALT |
| stop_req | input | 1 | Enter STOP |
| irq | input | 1 | Interrupt, wakes from HALT or STOP |
| stab_count | input | STAB_W | Main oscillator stabilization length in cycles |
| cpu_src | output | 2 | CPU clock select: 0 ring, 1 main, 2 subsystem |
| cpu_clk_en | output | 1 | CPU clock gate |
| main_osc_en | output | 1 | Main oscillator enable |
| ring_osc_en | output | 1 | Ring oscillator enable |
| sub_osc_en | output | 1 | Subsystem oscillator enable |
| wdt_clk_en | output | 1 | Watchdog clock gate |
| mcs | output | 1 | Status bit: CPU running from main clock |
| stab_done | output | 1 | Main oscillator stabilization complete |
| wr_err | output | 1 | One-cycle pulse on a rejected write |

## Verification
The assertions assume the following about the inputs:
- ring_sw_stop_opt changes only while reset is held.
- halt_req and stop_req arrive only in run mode and are never combined with a write in the same cycle.
- irq is raised only to wake from a low-power mode.

The stimulus keeps to these assumptions. It changes the strap only inside a reset phase and issues each power request as an isolated one-cycle pulse. It also holds stab_count constant across each phase, so the stabilization windows the bench predicts stay fixed.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

  localparam int CTRL_W     = 4;
  localparam int B_MAIN_OFF = 0;
  localparam int B_RING_OFF = 1;
  localparam int B_MAIN_SEL = 2;
  localparam int B_SUB_SEL  = 3;

  typedef enum logic [2:0] {
    ST_RING_ONLY = 3'd1,
    ST_RING_MAIN = 3'd2,
    ST_MAIN      = 3'd3,
    ST_MAIN_ONLY = 3'd4,
    ST_SUB       = 3'd5
  } clk_status_e;

  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_HALT = 2'd1,
    PM_STOP = 2'd2
  } pwr_mode_e;

  typedef enum logic [1:0] {
    SRC_RING = 2'd0,
    SRC_MAIN = 2'd1,
    SRC_SUB  = 2'd2
  } clk_src_e;

  function automatic logic [CTRL_W-1:0] ctrl_of_status(clk_status_e s);
    logic [CTRL_W-1:0] c;
    c = '0;
    case (s)
      ST_RING_ONLY: c[B_MAIN_OFF] = 1'b1;
      ST_RING_MAIN: c = '0;
      ST_MAIN:      c[B_MAIN_SEL] = 1'b1;
      ST_MAIN_ONLY: begin
        c[B_MAIN_SEL] = 1'b1;
        c[B_RING_OFF] = 1'b1;
      end
      ST_SUB: begin
        c[B_MAIN_SEL] = 1'b1;
        c[B_SUB_SEL]  = 1'b1;
      end
      default: c[B_MAIN_OFF] = 1'b1;
    endcase
    return c;
  endfunction

  function automatic clk_src_e src_of_status(clk_status_e s);
    case (s)
      ST_MAIN, ST_MAIN_ONLY: return SRC_MAIN;
      ST_SUB:                return SRC_SUB;
      default:               return SRC_RING;
    endcase
  endfunction

endpackage

// File: rtl/clkmode_rst_sync.sv
module clkmode_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/clkmode_xfer.sv
module clkmode_xfer
  import clkmode_pkg::*;
(
  input  clk_status_e       status,
  input  logic [CTRL_W-1:0] wr_ctrl,
  input  logic              mcs,
  input  logic              stab_done,
  input  logic              ring_stop_ok,
  output logic              legal,
  output clk_status_e       next_status
);
  logic [CTRL_W-1:0] cur_ctrl;

  always_comb begin
    cur_ctrl    = ctrl_of_status(status);
    legal       = 1'b0;
    next_status = status;
    if (wr_ctrl == cur_ctrl) begin
      legal = 1'b1;
    end else begin
      case (status)
        ST_RING_ONLY: begin
          if (wr_ctrl == ctrl_of_status(ST_RING_MAIN)) begin
            legal = 1'b1; next_status = ST_RING_MAIN;
          end
        end
        ST_RING_MAIN: begin
          if (wr_ctrl == ctrl_of_status(ST_RING_ONLY) && !mcs) begin
            legal = 1'b1; next_status = ST_RING_ONLY;
          end else if (wr_ctrl == ctrl_of_status(ST_MAIN) && stab_done) begin
            legal = 1'b1; next_status = ST_MAIN;
          end
        end
        ST_MAIN: begin
          if (wr_ctrl == ctrl_of_status(ST_RING_MAIN)) begin
            legal = 1'b1; next_status = ST_RING_MAIN;
          end else if (wr_ctrl == ctrl_of_status(ST_MAIN_ONLY) && mcs && ring_stop_ok) begin
            legal = 1'b1; next_status = ST_MAIN_ONLY;
          end else if (wr_ctrl == ctrl_of_status(ST_SUB)) begin
            legal = 1'b1; next_status = ST_SUB;
          end
        end
        ST_MAIN_ONLY, ST_SUB: begin
          if (wr_ctrl == ctrl_of_status(ST_MAIN)) begin
            legal = 1'b1; next_status = ST_MAIN;
          end
        end
        default: begin
          legal = 1'b0; next_status = status;
        end
      endcase
    end
  end
endmodule

// File: rtl/clkmode_stab.sv
module clkmode_stab #(
  parameter int STAB_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_en,
  input  logic [STAB_W-1:0] reload_val,
  output logic              done
);
  logic [STAB_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!osc_en)            cnt_d = reload_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = osc_en && (cnt_q == '0);

  // R5: once stable, the main oscillator stays stable while it keeps running
  assert_done_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_en && $past(osc_en) && $past(done)) |-> done);
endmodule

// File: rtl/clkmode_pwr.sv
module clkmode_pwr
  import clkmode_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      halt_req,
  input  logic      stop_req,
  input  logic      irq,
  output pwr_mode_e pmode
);
  pwr_mode_e pmode_q, pmode_d;

  always_comb begin
    pmode_d = pmode_q;
    case (pmode_q)
      PM_RUN: begin
        if (stop_req)      pmode_d = PM_STOP;
        else if (halt_req) pmode_d = PM_HALT;
      end
      PM_HALT, PM_STOP: begin
        if (irq) pmode_d = PM_RUN;
      end
      default: pmode_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pmode_q <= PM_RUN;
    else        pmode_q <= pmode_d;
  end

  assign pmode = pmode_q;

  assert_halt_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pmode_q == PM_HALT && !irq) |=> pmode_q == PM_HALT);
  assert_stop_wakes_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pmode_q == PM_STOP && irq) |=> pmode_q == PM_RUN);
endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
  import clkmode_pkg::*;
#(
  parameter int STAB_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ring_sw_stop_opt,
  input  logic              wr_en,
  input  logic [3:0]        wr_ctrl,
  input  logic              halt_req,
  input  logic              stop_req,
  input  logic              irq,
  input  logic [STAB_W-1:0] stab_count,
  output logic [1:0]        cpu_src,
  output logic              cpu_clk_en,
  output logic              main_osc_en,
  output logic              ring_osc_en,
  output logic              sub_osc_en,
  output logic              wdt_clk_en,
  output logic              mcs,
  output logic              stab_done,
  output logic              wr_err
);
  logic        rst_n_s;
  pwr_mode_e   pmode;
  clk_status_e status_q, status_d, xfer_next;
  clk_src_e    src;
  logic        xfer_legal, wr_accept, err_d, mcs_q, mcs_d, err_q;
  logic        running;

  clkmode_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  clkmode_pwr i_pwr (
    .clk(clk), .rst_n(rst_n_s), .halt_req(halt_req), .stop_req(stop_req),
    .irq(irq), .pmode(pmode));

  clkmode_xfer i_xfer (
    .status(status_q), .wr_ctrl(wr_ctrl), .mcs(mcs_q), .stab_done(stab_done),
    .ring_stop_ok(ring_sw_stop_opt), .legal(xfer_legal), .next_status(xfer_next));

  clkmode_stab #(.STAB_W(STAB_W)) i_stab (
    .clk(clk), .rst_n(rst_n_s), .osc_en(main_osc_en),
    .reload_val(stab_count), .done(stab_done));

  assign running = (pmode == PM_RUN);

  always_comb begin
    wr_accept = wr_en && running && xfer_legal;
    err_d     = wr_en && !(running && xfer_legal);
    status_d  = wr_accept ? xfer_next : status_q;
    mcs_d     = (status_q == ST_MAIN) || (status_q == ST_MAIN_ONLY);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      status_q <= ST_RING_ONLY;
      mcs_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      mcs_q    <= mcs_d;
      err_q    <= err_d;
    end
  end

  always_comb begin
    src         = src_of_status(status_q);
    main_osc_en = (pmode != PM_STOP) && (status_q != ST_RING_ONLY);
    ring_osc_en = !ring_sw_stop_opt ||
                  ((pmode != PM_STOP) && (status_q != ST_MAIN_ONLY));
    sub_osc_en  = (status_q == ST_SUB);
    cpu_clk_en  = running && ((src != SRC_MAIN) || stab_done);
    wdt_clk_en  = ring_osc_en && !(ring_sw_stop_opt && !running);
  end

  assign cpu_src = src;
  assign mcs     = mcs_q;
  assign wr_err  = err_q;

  assert_reject_keeps_status_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    err_q |-> $stable(status_q));
  assert_main_switch_stable_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(mcs_q) |-> stab_done);
  assert_ring_off_on_main_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    !ring_osc_en |-> (src == SRC_MAIN || pmode == PM_STOP));
  assert_no_sub_to_ring_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($past(src) == SRC_SUB) |-> src != SRC_RING);
  assert_no_ring_to_sub_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($past(src) == SRC_RING) |-> src != SRC_SUB);
  assert_mcs_lags_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(src == SRC_MAIN) |-> !mcs_q);
  assert_ring_kept_R12: assert property (@(posedge clk) disable iff (!rst_n_s)
    !ring_sw_stop_opt |-> (ring_osc_en && wdt_clk_en));
endmodule

// File: tb/test_clkmode_ctrl.sv
module test_clkmode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int STAB_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic opt = 1'b1;
  logic wr_en = 1'b0;
  logic [3:0] wr_ctrl = 4'b0001;
  logic halt_req = 1'b0, stop_req = 1'b0, irq = 1'b0;
  logic [STAB_W-1:0] stab_count = 8'd4;
  logic [1:0] cpu_src;
  logic cpu_clk_en, main_osc_en, ring_osc_en, sub_osc_en, wdt_clk_en, mcs, stab_done, wr_err;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct { string req; logic [9:0] mask; logic [9:0] val; } exp_t;
  exp_t sb_q[$];

  localparam logic [9:0] M_ALL  = 10'h3FF;
  localparam logic [9:0] M_CEN  = 10'h040;
  localparam logic [9:0] M_DONE = 10'h080;
  localparam logic [9:0] M_MCS  = 10'h100;
  localparam logic [9:0] M_ERR  = 10'h200;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkmode_ctrl #(.STAB_W(STAB_W)) i_clkmode_ctrl (
    .clk(clk), .rst_n(rst_n), .ring_sw_stop_opt(opt), .wr_en(wr_en), .wr_ctrl(wr_ctrl),
    .halt_req(halt_req), .stop_req(stop_req), .irq(irq), .stab_count(stab_count),
    .cpu_src(cpu_src), .cpu_clk_en(cpu_clk_en), .main_osc_en(main_osc_en),
    .ring_osc_en(ring_osc_en), .sub_osc_en(sub_osc_en), .wdt_clk_en(wdt_clk_en),
    .mcs(mcs), .stab_done(stab_done), .wr_err(wr_err));

  wire [9:0] obs = {wr_err, mcs, stab_done, cpu_clk_en, wdt_clk_en,
                    sub_osc_en, ring_osc_en, main_osc_en, cpu_src};

  function automatic logic [9:0] ex(logic [1:0] src, logic mn, logic rg, logic sb,
                                    logic wd, logic ce, logic dn, logic mc, logic er);
    return {er, mc, dn, ce, wd, sb, rg, mn, src};
  endfunction

  task automatic push(string r, logic [9:0] m, logic [9:0] v);
    exp_t e;
    e.req = r; e.mask = m; e.val = v;
    sb_q.push_back(e);
  endtask

  // monitor: compare queued expectations at the falling edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if ((obs & e.mask) !== (e.val & e.mask)) begin
        failures++;
        $display("FAIL %s actual=%b expected=%b mask=%b", e.req, obs, e.val, e.mask);
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [3:0] v);
    wr_en = 1'b1; wr_ctrl = v; cyc(); wr_en = 1'b0;
  endtask

  task automatic do_halt();  halt_req = 1'b1; cyc(); halt_req = 1'b0; endtask
  task automatic do_stop();  stop_req = 1'b1; cyc(); stop_req = 1'b0; endtask
  task automatic do_irq();   irq = 1'b1; cyc(); irq = 1'b0; endtask

  task automatic reset_phase(logic o);
    rst_n = 1'b0; opt = o;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (4) cyc();
    push("R1 reset state", M_ALL, ex(2'd0,0,1,0,1,1,0,0,0));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // ---------------- phase 1: software ring stop allowed ----------------
    reset_phase(1'b1);
    wr(4'b0101);
    push("R8 illegal write from ring-only", M_ALL, ex(2'd0,0,1,0,1,1,0,0,1));
    cyc();
    push("R8 error is one pulse", M_ERR, 10'h000);
    wr(4'b0000);
    push("R2 main oscillator started", M_ALL, ex(2'd0,1,1,0,1,1,0,0,0));
    wr(4'b0100);
    push("R4 main select before stable", M_ALL, ex(2'd0,1,1,0,1,1,0,0,1));
    cyc(); cyc();
    push("R5 not yet stable", M_DONE, 10'h000);
    cyc();
    push("R5 stable after count", M_DONE, M_DONE);
    wr(4'b0100);
    push("R9 switch to main, mcs lags", M_ALL, ex(2'd1,1,1,0,1,1,1,0,0));
    wr(4'b0110);
    push("R6 ring stop rejected while mcs low", M_ALL, ex(2'd1,1,1,0,1,1,1,1,1));
    wr(4'b0110);
    push("R6 ring stopped", M_ALL, ex(2'd1,1,0,0,0,1,1,1,0));
    wr(4'b1110);
    push("R7 subsystem from main-only rejected", M_ALL, ex(2'd1,1,0,0,0,1,1,1,1));
    wr(4'b0000);
    push("R8 multi-bit change rejected", M_ALL, ex(2'd1,1,0,0,0,1,1,1,1));
    wr(4'b0100);
    push("R6 ring restarted", M_ALL, ex(2'd1,1,1,0,1,1,1,1,0));
    wr(4'b1100);
    push("R7 subsystem selected", M_ALL, ex(2'd2,1,1,1,1,1,1,1,0));
    cyc();
    push("R9 mcs falls one cycle later", M_MCS, 10'h000);
    wr(4'b1000);
    push("R7 subsystem to ring rejected", M_ALL, ex(2'd2,1,1,1,1,1,1,0,1));
    wr(4'b1100);
    push("R8 same word is a no-op", M_ALL, ex(2'd2,1,1,1,1,1,1,0,0));
    do_stop();
    push("R11 stop keeps subsystem", M_ALL, ex(2'd2,0,0,1,0,0,0,0,0));
    do_irq();
    push("R11 wake on subsystem", M_ALL, ex(2'd2,1,1,1,1,1,0,0,0));
    repeat (4) cyc();
    push("R5 restabilized after stop", M_DONE, M_DONE);
    wr(4'b0100);
    push("R7 back to main", M_ALL, ex(2'd1,1,1,0,1,1,1,0,0));
    cyc();
    do_halt();
    push("R10 R12 halt", M_ALL, ex(2'd1,1,1,0,0,0,1,1,0));
    wr(4'b0000);
    push("R13 write during halt", M_ALL, ex(2'd1,1,1,0,0,0,1,1,1));
    do_irq();
    push("R10 resume same status", M_ALL, ex(2'd1,1,1,0,1,1,1,1,0));
    do_stop();
    push("R11 R12 stop on main", M_ALL, ex(2'd1,0,0,0,0,0,0,1,0));
    do_irq();
    push("R11 cpu waits for stability", M_ALL, ex(2'd1,1,1,0,1,0,0,1,0));
    cyc(); cyc(); cyc();
    push("R11 still waiting", M_CEN, 10'h000);
    cyc();
    push("R11 cpu clock back", M_CEN | M_DONE, M_CEN | M_DONE);
    wr(4'b0000);
    push("R9 back to ring, mcs lags", M_ALL, ex(2'd0,1,1,0,1,1,1,1,0));
    wr(4'b0001);
    push("R3 main stop rejected while mcs high", M_ALL, ex(2'd0,1,1,0,1,1,1,0,1));
    wr(4'b0001);
    push("R3 main oscillator stopped", M_ALL, ex(2'd0,0,1,0,1,1,0,0,0));

    // ---------------- phase 2: ring stop not allowed ----------------
    reset_phase(1'b0);
    wr(4'b0000);
    repeat (4) cyc();
    wr(4'b0100);
    cyc();
    wr(4'b0110);
    push("R6 ring stop rejected without option", M_ALL, ex(2'd1,1,1,0,1,1,1,1,1));
    do_halt();
    push("R12 watchdog kept in halt", M_ALL, ex(2'd1,1,1,0,1,0,1,1,0));
    do_irq();
    do_stop();
    push("R11 R12 ring and watchdog kept in stop", M_ALL, ex(2'd1,0,1,0,1,0,0,1,0));
    do_irq();
    repeat (3) cyc();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule